// File: doc/BRIEF.md
# Transaction Tracking Unit

This block keeps the transactional state of one processor core that runs hardware transactions over a small, directly indexed array of cache lines. The core issues four commands: open a transaction, close one, abandon one, and query whether it is inside one. Nested transactions are folded into one depth counter, so only the outermost open and the final close have visible effects. Each cache line has a tracking bit. The unit sets that bit for every line the core touches while it is inside a transaction.

Two snoop events can break a transaction. The first is an incoming invalidation of a tracked line. The second is a remote read of a tracked line that is held in the Modified state. Either one, an explicit abandon command, or an open command that would go past the nesting limit rolls back the whole nest. The unit then pulses the strobes that restore the register checkpoint and discard the store buffer, and it sends out the set of tracked lines for invalidation. A successful final close commits: it drains the store buffer and clears all tracking bits.

The controller is a two-state machine, IDLE and ACTIVE. Its named transitions are OPEN (IDLE to ACTIVE on a begin command), NEST and UNNEST (ACTIVE to ACTIVE on a begin or end command below the limits), COMMIT (ACTIVE to IDLE on an end command at depth 1) and ROLLBACK (ACTIVE to IDLE on any abort cause). All strobes are registered and appear in the cycle after the event that causes them.

Top module: `txn_track_unit`

## Requirements
- R1: A begin command (cmd_op 0) while idle sets txn_depth to 1 and raises txn_active. In the next cycle ckpt_save and sb_flush each pulse for exactly one cycle.
- R2: A begin command while active and below MAX_DEPTH raises txn_depth by one and pulses no strobe. A begin command at depth MAX_DEPTH causes a rollback with abort_code 3.
- R3: An access (acc_valid) while txn_active is 1 sets bit acc_idx of txn_bits, which is visible in the next cycle. Accesses made while idle leave txn_bits at zero.
- R4: An invalidation snoop to a line whose tracking bit is set causes a rollback with abort_code 1. An invalidation snoop to a line whose bit is clear has no effect.
- R5: A remote read snoop with snp_rd_mod 1 to a tracked line causes a rollback with abort_code 1. The same snoop has no effect when snp_rd_mod is 0 or when the line is untracked.
- R6: In the cycle after a rollback cause, abort_pulse, sb_clear and ckpt_restore are 1, and line_inv_mask equals the tracking bits held before the rollback. In that same cycle txn_depth and txn_bits are 0.
- R7: An end command (cmd_op 1) while active lowers txn_depth by one. At depth 1 the end command commits: in the next cycle commit_pulse and sb_flush are 1, txn_bits is 0 and line_inv_mask is 0.
- R8: An abort command (cmd_op 2) while active rolls back the whole nest at any depth with abort_code 2. An abort command while idle has no effect.
- R9: An end command while idle pulses end_err in the next cycle and changes nothing else.
- R10: A test command (cmd_op 3) pulses test_valid in the next cycle, with test_in_txn equal to txn_active at the time of the command.
- R11: When a conflict and an abort command or an overflowing begin arrive in the same cycle, abort_code is 1 (conflict wins over explicit 2 and overflow 3). abort_code is 0 whenever abort_pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 begin, 1 end, 2 abort, 3 test |
| acc_valid | input | 1 | Core read or write this cycle |
| acc_idx | input | IDX_W | Line index of the core access |
| snp_inv_valid | input | 1 | Incoming invalidation snoop |
| snp_inv_idx | input | IDX_W | Line index of the invalidation |
| snp_rd_valid | input | 1 | Observed remote read snoop |
| snp_rd_idx | input | IDX_W | Line index of the remote read |
| snp_rd_mod | input | 1 | That line is held Modified |
| txn_active | output | 1 | Inside a transaction (depth above 0) |
| txn_depth | output | DEPTH_W | Current nesting depth |
| txn_bits | output | NUM_LINES | Per-line tracking bits |
| ckpt_save | output | 1 | Take register checkpoint |
| ckpt_restore | output | 1 | Restore register checkpoint |
| sb_flush | output | 1 | Drain store buffer to cache |
| sb_clear | output | 1 | Discard store buffer |
| line_inv_mask | output | NUM_LINES | Lines to invalidate on rollback |
| abort_pulse | output | 1 | Rollback took place |
| abort_code | output | 2 | 1 conflict, 2 explicit, 3 overflow |
| commit_pulse | output | 1 | Outermost transaction committed |
| end_err | output | 1 | End command received while idle |
| test_valid | output | 1 | Test reply present |
| test_in_txn | output | 1 | Test reply value |

## Verification
A wrong depth count shows on txn_depth at once. It then moves the commit or the overflow rollback by one or more commands, so commit_pulse or abort_pulse turns up a cycle early or late. A stuck or missing tracking bit shows on txn_bits in the cycle after the access. It then shows again as a missed or spurious conflict rollback and as a wrong line_inv_mask in the cycle after the snoop. A state machine out of step with the counter shows as txn_active disagreeing with txn_depth, or as a test reply with the wrong value one cycle after the query.

// File: rtl/txn_track_pkg.sv
package txn_track_pkg;

    typedef enum logic [1:0] {
        OP_BEGIN = 2'd0,
        OP_END   = 2'd1,
        OP_ABORT = 2'd2,
        OP_TEST  = 2'd3
    } txn_op_e;

    typedef enum logic [1:0] {
        AB_NONE     = 2'd0,
        AB_CONFLICT = 2'd1,
        AB_EXPLICIT = 2'd2,
        AB_OVERFLOW = 2'd3
    } abort_code_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } txn_state_e;

endpackage

// File: rtl/txn_nest_ctr.sv
module txn_nest_ctr #(
    parameter int MAX_DEPTH = 4,
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               dec,
    input  logic               clr,
    output logic [DEPTH_W-1:0] depth,
    output logic               at_one,
    output logic               at_max
);
    localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);
    localparam logic [DEPTH_W-1:0] TOP = DEPTH_W'(MAX_DEPTH);

    logic [DEPTH_W-1:0] depth_q;

    // Clear wins over a count step; inc and dec are never raised together.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (clr) begin
            depth_q <= '0;
        end else if (inc && depth_q != TOP) begin
            depth_q <= depth_q + ONE;
        end else if (dec && depth_q != '0) begin
            depth_q <= depth_q - ONE;
        end
    end

    assign depth  = depth_q;
    assign at_one = (depth_q == ONE);
    assign at_max = (depth_q == TOP);
endmodule

// File: rtl/txn_tag_bits.sv
module txn_tag_bits #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 track_en,
    input  logic                 clr_bits,
    input  logic                 cap_mask,
    input  logic                 acc_valid,
    input  logic [IDX_W-1:0]     acc_idx,
    input  logic                 inv_valid,
    input  logic [IDX_W-1:0]     inv_idx,
    input  logic                 rd_valid,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic                 rd_mod,
    output logic [NUM_LINES-1:0] bits,
    output logic                 conflict,
    output logic [NUM_LINES-1:0] inv_mask
);
    logic [NUM_LINES-1:0] bits_q;
    logic [NUM_LINES-1:0] inv_q;
    logic [NUM_LINES-1:0] inv_hit;
    logic [NUM_LINES-1:0] rd_hit;

    // One tracking flop per line, set by a tracked access, cleared on exit.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[g] <= 1'b0;
            end else if (clr_bits) begin
                bits_q[g] <= 1'b0;
            end else if (track_en && acc_valid && acc_idx == IDX_W'(g)) begin
                bits_q[g] <= 1'b1;
            end
        end

        assign inv_hit[g] = inv_valid && (inv_idx == IDX_W'(g)) && bits_q[g];
        assign rd_hit[g]  = rd_valid && rd_mod && (rd_idx == IDX_W'(g)) && bits_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_q <= '0;
        end else begin
            inv_q <= cap_mask ? bits_q : '0;
        end
    end

    assign conflict = |(inv_hit | rd_hit);
    assign bits     = bits_q;
    assign inv_mask = inv_q;
endmodule

// File: rtl/txn_ctrl.sv
module txn_ctrl
    import txn_track_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  txn_op_e cmd_op,
    input  logic    conflict,
    input  logic    at_one,
    input  logic    at_max,
    output logic    active,
    output logic    inc,
    output logic    dec,
    output logic    clr_depth,
    output logic    track_en,
    output logic    clr_bits,
    output logic    cap_mask,
    output logic    ckpt_save,
    output logic    ckpt_restore,
    output logic    sb_flush,
    output logic    sb_clear,
    output logic    abort_pulse,
    output logic [1:0] abort_code,
    output logic    commit_pulse,
    output logic    end_err,
    output logic    test_valid,
    output logic    test_in_txn
);
    txn_state_e  state_q, state_d;
    abort_code_e cause;
    logic        is_begin, is_end, is_abort, is_test;
    logic        open_now, rollback_now, commit_now, idle_end;

    logic        save_q, restore_q, flush_q, clear_q, abort_q;
    logic        commit_q, err_q, tv_q, tin_q;
    abort_code_e code_q;

    assign is_begin = cmd_valid && (cmd_op == OP_BEGIN);
    assign is_end   = cmd_valid && (cmd_op == OP_END);
    assign is_abort = cmd_valid && (cmd_op == OP_ABORT);
    assign is_test  = cmd_valid && (cmd_op == OP_TEST);

    // Transition decode: conflict outranks explicit abort, which outranks overflow.
    always_comb begin
        state_d      = state_q;
        open_now     = 1'b0;
        rollback_now = 1'b0;
        commit_now   = 1'b0;
        idle_end     = 1'b0;
        cause        = AB_NONE;
        unique case (state_q)
            ST_IDLE: begin
                idle_end = is_end;
                if (is_begin) begin
                    open_now = 1'b1;
                    state_d  = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (conflict) begin
                    cause = AB_CONFLICT;
                end else if (is_abort) begin
                    cause = AB_EXPLICIT;
                end else if (is_begin && at_max) begin
                    cause = AB_OVERFLOW;
                end
                rollback_now = (cause != AB_NONE);
                commit_now   = !rollback_now && is_end && at_one;
                if (rollback_now || commit_now) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Commands to the depth counter and the tracking array.
    always_comb begin
        inc       = open_now || (state_q == ST_ACTIVE && is_begin && !rollback_now);
        dec       = state_q == ST_ACTIVE && is_end && !rollback_now;
        clr_depth = rollback_now;
        track_en  = state_q == ST_ACTIVE && !rollback_now && !commit_now;
        clr_bits  = rollback_now || commit_now;
        cap_mask  = rollback_now;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered strobes, valid for one cycle after the causing event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            save_q    <= 1'b0;
            restore_q <= 1'b0;
            flush_q   <= 1'b0;
            clear_q   <= 1'b0;
            abort_q   <= 1'b0;
            code_q    <= AB_NONE;
            commit_q  <= 1'b0;
            err_q     <= 1'b0;
            tv_q      <= 1'b0;
            tin_q     <= 1'b0;
        end else begin
            save_q    <= open_now;
            restore_q <= rollback_now;
            flush_q   <= open_now || commit_now;
            clear_q   <= rollback_now;
            abort_q   <= rollback_now;
            code_q    <= cause;
            commit_q  <= commit_now;
            err_q     <= idle_end;
            tv_q      <= is_test;
            tin_q     <= is_test && (state_q == ST_ACTIVE);
        end
    end

    assign active       = (state_q == ST_ACTIVE);
    assign ckpt_save    = save_q;
    assign ckpt_restore = restore_q;
    assign sb_flush     = flush_q;
    assign sb_clear     = clear_q;
    assign abort_pulse  = abort_q;
    assign abort_code   = code_q;
    assign commit_pulse = commit_q;
    assign end_err      = err_q;
    assign test_valid   = tv_q;
    assign test_in_txn  = tin_q;
endmodule

// File: rtl/txn_track_unit.sv
module txn_track_unit
    import txn_track_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int MAX_DEPTH = 4,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic                 acc_valid,
    input  logic [IDX_W-1:0]     acc_idx,
    input  logic                 snp_inv_valid,
    input  logic [IDX_W-1:0]     snp_inv_idx,
    input  logic                 snp_rd_valid,
    input  logic [IDX_W-1:0]     snp_rd_idx,
    input  logic                 snp_rd_mod,
    output logic                 txn_active,
    output logic [DEPTH_W-1:0]   txn_depth,
    output logic [NUM_LINES-1:0] txn_bits,
    output logic                 ckpt_save,
    output logic                 ckpt_restore,
    output logic                 sb_flush,
    output logic                 sb_clear,
    output logic [NUM_LINES-1:0] line_inv_mask,
    output logic                 abort_pulse,
    output logic [1:0]           abort_code,
    output logic                 commit_pulse,
    output logic                 end_err,
    output logic                 test_valid,
    output logic                 test_in_txn
);
    logic conflict, at_one, at_max;
    logic inc, dec, clr_depth, track_en, clr_bits, cap_mask;

    txn_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (txn_op_e'(cmd_op)),
        .conflict     (conflict),
        .at_one       (at_one),
        .at_max       (at_max),
        .active       (txn_active),
        .inc          (inc),
        .dec          (dec),
        .clr_depth    (clr_depth),
        .track_en     (track_en),
        .clr_bits     (clr_bits),
        .cap_mask     (cap_mask),
        .ckpt_save    (ckpt_save),
        .ckpt_restore (ckpt_restore),
        .sb_flush     (sb_flush),
        .sb_clear     (sb_clear),
        .abort_pulse  (abort_pulse),
        .abort_code   (abort_code),
        .commit_pulse (commit_pulse),
        .end_err      (end_err),
        .test_valid   (test_valid),
        .test_in_txn  (test_in_txn)
    );

    txn_nest_ctr #(.MAX_DEPTH(MAX_DEPTH)) u_nest (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (inc),
        .dec    (dec),
        .clr    (clr_depth),
        .depth  (txn_depth),
        .at_one (at_one),
        .at_max (at_max)
    );

    txn_tag_bits #(.NUM_LINES(NUM_LINES)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .track_en  (track_en),
        .clr_bits  (clr_bits),
        .cap_mask  (cap_mask),
        .acc_valid (acc_valid),
        .acc_idx   (acc_idx),
        .inv_valid (snp_inv_valid),
        .inv_idx   (snp_inv_idx),
        .rd_valid  (snp_rd_valid),
        .rd_idx    (snp_rd_idx),
        .rd_mod    (snp_rd_mod),
        .bits      (txn_bits),
        .conflict  (conflict),
        .inv_mask  (line_inv_mask)
    );
endmodule

// File: rtl/txn_track_chk.sv
module txn_track_chk #(
    parameter int NUM_LINES = 8,
    parameter int MAX_DEPTH = 4,
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 txn_active,
    input logic [DEPTH_W-1:0]   txn_depth,
    input logic [NUM_LINES-1:0] txn_bits,
    input logic                 ckpt_save,
    input logic                 ckpt_restore,
    input logic                 sb_clear,
    input logic [NUM_LINES-1:0] line_inv_mask,
    input logic                 abort_pulse,
    input logic [1:0]           abort_code,
    input logic                 commit_pulse,
    input logic                 end_err
);
    AST_ACTIVE_MATCHES_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        txn_active == (txn_depth != '0)); // R1

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        txn_depth <= DEPTH_W'(MAX_DEPTH)); // R2

    AST_IDLE_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_active |-> txn_bits == '0); // R3

    AST_SAVE_AT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |-> txn_depth == DEPTH_W'(1) && $past(!txn_active)); // R1

    AST_ROLLBACK_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> txn_depth == '0 && txn_bits == '0 && sb_clear && ckpt_restore); // R6

    AST_ROLLBACK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> line_inv_mask == $past(txn_bits)); // R6

    AST_CODE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse == (abort_code != 2'd0)); // R11

    AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> txn_bits == '0 && line_inv_mask == '0 && !sb_clear
                         && $past(txn_depth) == DEPTH_W'(1)); // R7

    AST_END_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_err |-> $past(!txn_active) && $stable(txn_depth)); // R9
endmodule

bind txn_track_unit txn_track_chk #(.NUM_LINES(NUM_LINES), .MAX_DEPTH(MAX_DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .txn_active    (txn_active),
    .txn_depth     (txn_depth),
    .txn_bits      (txn_bits),
    .ckpt_save     (ckpt_save),
    .ckpt_restore  (ckpt_restore),
    .sb_clear      (sb_clear),
    .line_inv_mask (line_inv_mask),
    .abort_pulse   (abort_pulse),
    .abort_code    (abort_code),
    .commit_pulse  (commit_pulse),
    .end_err       (end_err)
);

// File: tb/test_txn_track_unit.sv
`timescale 1ns/1ps
module test_txn_track_unit;
    localparam int NL  = 8;
    localparam int MD  = 4;
    localparam int IW  = $clog2(NL);
    localparam int DW  = $clog2(MD + 1);

    typedef struct packed {
        logic          active;
        logic [DW-1:0] depth;
        logic [NL-1:0] bits;
        logic          save;
        logic          restore;
        logic          flush;
        logic          clear;
        logic [NL-1:0] inv;
        logic          abort;
        logic [1:0]    code;
        logic          commit;
        logic          err;
        logic          tv;
        logic          tin;
    } snap_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic acc_valid = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic snp_inv_valid = 1'b0;
    logic [IW-1:0] snp_inv_idx = '0;
    logic snp_rd_valid = 1'b0;
    logic [IW-1:0] snp_rd_idx = '0;
    logic snp_rd_mod = 1'b0;

    logic          txn_active, ckpt_save, ckpt_restore, sb_flush, sb_clear;
    logic [DW-1:0] txn_depth;
    logic [NL-1:0] txn_bits, line_inv_mask;
    logic          abort_pulse, commit_pulse, end_err, test_valid, test_in_txn;
    logic [1:0]    abort_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    snap_t exp_q[$];
    string tag_q[$];

    int            m_depth = 0;
    logic [NL-1:0] m_bits  = '0;

    always #10 clk = ~clk;

    txn_track_unit #(.NUM_LINES(NL), .MAX_DEPTH(MD)) i_txn_track_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .acc_valid(acc_valid), .acc_idx(acc_idx),
        .snp_inv_valid(snp_inv_valid), .snp_inv_idx(snp_inv_idx),
        .snp_rd_valid(snp_rd_valid), .snp_rd_idx(snp_rd_idx), .snp_rd_mod(snp_rd_mod),
        .txn_active(txn_active), .txn_depth(txn_depth), .txn_bits(txn_bits),
        .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore), .sb_flush(sb_flush),
        .sb_clear(sb_clear), .line_inv_mask(line_inv_mask), .abort_pulse(abort_pulse),
        .abort_code(abort_code), .commit_pulse(commit_pulse), .end_err(end_err),
        .test_valid(test_valid), .test_in_txn(test_in_txn)
    );

    function automatic snap_t observe();
        snap_t a;
        a = '{txn_active, txn_depth, txn_bits, ckpt_save, ckpt_restore, sb_flush,
              sb_clear, line_inv_mask, abort_pulse, abort_code, commit_pulse,
              end_err, test_valid, test_in_txn};
        return a;
    endfunction

    // Monitor: compare one expected item per cycle, a quarter period after the edge.
    always begin
        @(posedge clk);
        #5;
        if (exp_q.size() > 0) begin
            snap_t e;
            snap_t a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = observe();
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    // Driver: applies one cycle of stimulus and pushes the outcome the requirements predict.
    task automatic step(input logic cv, input logic [1:0] op,
                        input logic av, input int ai,
                        input logic iv, input int ii,
                        input logic rv, input int ri, input logic rm,
                        input string tag);
        snap_t e;
        logic  act;
        logic  conf;
        cmd_valid = cv; cmd_op = op;
        acc_valid = av; acc_idx = IW'(ai);
        snp_inv_valid = iv; snp_inv_idx = IW'(ii);
        snp_rd_valid = rv; snp_rd_idx = IW'(ri); snp_rd_mod = rm;
        e    = '0;
        act  = (m_depth != 0);
        conf = act && ((iv && m_bits[ii]) || (rv && rm && m_bits[ri]));
        if (!act) begin
            if (cv && op == 2'd0) begin
                m_depth = 1; e.save = 1'b1; e.flush = 1'b1;
            end
            if (cv && op == 2'd1) e.err = 1'b1;
        end else if (conf || (cv && op == 2'd2) || (cv && op == 2'd0 && m_depth == MD)) begin
            e.code    = conf ? 2'd1 : (op == 2'd2 ? 2'd2 : 2'd3);
            e.abort   = 1'b1;
            e.clear   = 1'b1;
            e.restore = 1'b1;
            e.inv     = m_bits;
            m_bits    = '0;
            m_depth   = 0;
        end else begin
            if (av) m_bits[ai] = 1'b1;
            if (cv && op == 2'd0) m_depth++;
            if (cv && op == 2'd1) begin
                if (m_depth == 1) begin
                    e.commit = 1'b1; e.flush = 1'b1; m_bits = '0;
                end
                m_depth--;
            end
        end
        if (cv && op == 2'd3) begin
            e.tv  = 1'b1;
            e.tin = act;
        end
        e.active = (m_depth != 0);
        e.depth  = DW'(m_depth);
        e.bits   = m_bits;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] op, input string tag);
        step(1'b1, op, 1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, tag);
    endtask
    task automatic acc(input int idx, input string tag);
        step(1'b0, 2'd0, 1'b1, idx, 1'b0, 0, 1'b0, 0, 1'b0, tag);
    endtask
    task automatic inv(input int idx, input string tag);
        step(1'b0, 2'd0, 1'b0, 0, 1'b1, idx, 1'b0, 0, 1'b0, tag);
    endtask
    task automatic rrd(input int idx, input logic md, input string tag);
        step(1'b0, 2'd0, 1'b0, 0, 1'b0, 0, 1'b1, idx, md, tag);
    endtask
    task automatic nop(input string tag);
        step(1'b0, 2'd0, 1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (observe() !== '0) begin
            bad++;
            $display("FAIL R1 reset actual=%h expected=%h", observe(), snap_t'('0));
        end
        rst_n = 1'b1;
        @(negedge clk);

        cmd(2'd3, "R10 test while idle");
        cmd(2'd1, "R9 end while idle");
        cmd(2'd2, "R8 abort while idle ignored");
        acc(3, "R3 access while idle untracked");
        cmd(2'd0, "R1 outermost begin");
        acc(2, "R3 track line 2");
        acc(5, "R3 track line 5");
        inv(3, "R4 invalidate untracked line");
        rrd(2, 1'b0, "R5 remote read clean tracked line");
        rrd(6, 1'b1, "R5 remote read modified untracked line");
        cmd(2'd3, "R10 test while active");
        cmd(2'd0, "R2 nested begin depth 2");
        cmd(2'd0, "R2 nested begin depth 3");
        cmd(2'd1, "R7 inner end");
        rrd(5, 1'b1, "R5 R6 remote read modified tracked line");
        nop("R6 after rollback");

        cmd(2'd0, "R1 begin again");
        acc(0, "R3 track line 0");
        cmd(2'd1, "R7 outermost end commits");
        nop("R7 after commit");

        cmd(2'd0, "R2 begin 1");
        cmd(2'd0, "R2 begin 2");
        acc(1, "R3 track line 1");
        cmd(2'd0, "R2 begin 3");
        cmd(2'd0, "R2 begin 4");
        cmd(2'd0, "R2 begin past limit overflows");

        cmd(2'd0, "R8 begin");
        cmd(2'd0, "R8 nested begin");
        acc(7, "R3 track line 7");
        cmd(2'd2, "R8 explicit abort whole nest");

        cmd(2'd0, "R4 begin");
        acc(1, "R3 track line 1");
        inv(1, "R4 invalidate tracked line");

        cmd(2'd0, "R11 begin");
        acc(4, "R3 track line 4");
        step(1'b1, 2'd2, 1'b0, 0, 1'b1, 4, 1'b0, 0, 1'b0, "R11 conflict beats explicit");
        cmd(2'd0, "R11 begin");
        cmd(2'd0, "R11 begin 2");
        cmd(2'd0, "R11 begin 3");
        acc(6, "R11 track line 6");
        cmd(2'd0, "R11 begin 4");
        step(1'b1, 2'd0, 1'b0, 0, 1'b0, 0, 1'b1, 6, 1'b1, "R11 conflict beats overflow");
        nop("R11 drain");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule